// File: doc/BRIEF.md
# TMDS Lane Encoder with Serial Output

This block produces one lane of a transition-minimized differential video link. It runs on the bit clock, which is ten times the pixel rate. An internal divide-by-ten phase counter marks the pixel rate with a one-cycle strobe. On the strobe edge the lane samples an 8-bit pixel byte, a 2-bit control pair and a data-enable input.

When data-enable is high, the byte is coded in two steps:
- A chain of XOR or XNOR operations reduces bit transitions. The resulting 9-bit word carries a flag that records which operation was used.
- The lower eight bits are then conditionally inverted, based on a signed running disparity, so that the line stays DC-balanced.

When data-enable is low, one of four fixed 10-bit tokens is sent instead, and the disparity is cleared. The 10-bit character is held on a parallel output. It is also loaded into a shift register that sends it least significant bit first, one bit per clock, with no gap between characters.

A full link uses three identical instances of this lane. They share the bit clock and therefore stay in phase.

Top module: `tmds_lane`

## Requirements
- R1: While reset is high and after its release, `char_out` equals the 00 control token 10'b1101010100 (bit 9 on the left), the disparity is zero, and `ser_out` sends that token LSB first until the first character is loaded.
- R2: `pix_stb` is high for exactly one clock in every ten, with the first pulse nine clocks after reset is released. The inputs are sampled at the rising edge where `pix_stb` is high, and `char_out` takes the new character at that edge.
- R3: With `de_in` low, the character is selected by `ctl_in` (bit 1, bit 0) as follows: 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011.
- R4: A control character resets the running disparity to zero. The first data character after it therefore has bit 9 equal to the inverse of bit 8.
- R5 (stage one): bit 0 is the data bit itself. Each higher bit i is q[i-1] XOR d[i], or XNOR instead when the byte has more than four ones, or exactly four ones with d[0]=0. Bit 8 is 1 for XOR. Inverting bits 7:0 when bit 9 is set and undoing the chain recovers the byte.
- R6 (stage two): Let n1 be the number of ones in stage-one bits 7:0.
  - If the disparity is zero or n1=4, the lane inverts exactly when stage-one bit 8 is 0.
  - Otherwise it inverts when the disparity and (n1−4) have the same sign.
  - Bit 9 marks inversion, bit 8 carries the stage-one flag, and bits 7:0 are the possibly inverted data.
- R7: After each data character the disparity changes by (ones − zeros) of the 10-bit character sent. Its magnitude never exceeds 10.
- R8: `ser_out` sends each character LSB first. It sends bit 0 in the clock after the load edge and bit 9 in the clock with `pix_stb` high, so the stream is continuous.
- R9: `char_out` does not change except at a `pix_stb` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, ten times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 8 | Pixel byte, sampled at the strobe edge |
| ctl_in | input | 2 | Control pair used when data-enable is low |
| de_in | input | 1 | Data enable: 1 selects the byte, 0 selects a token |
| pix_stb | output | 1 | Pixel-rate strobe, marks the sampling edge |
| char_out | output | 10 | Current 10-bit character |
| ser_out | output | 1 | Serial bit stream, LSB first |

## Verification
The hardest states to reach are the nonzero disparity levels combined with a byte whose stage-one word has exactly four ones or leans the same way as the disparity. These states exist only after a run of earlier data characters and cannot be set directly.

The bench therefore sweeps all 256 bytes in one unbroken data run, so that the disparity wanders across its range. It then sweeps all 256 bytes again, each one straight after a control character, to cover the zero-disparity branch. Finally it sends long random runs with sparse control characters. Every character received on the serial pin is decoded back to its byte, and the received imbalance is accumulated and checked against the bound.

// File: rtl/tmds_pkg.sv
package tmds_pkg;
  localparam int BYTE_W = 8;
  localparam int SYM_W  = 10;
  localparam int DISP_W = 6;

  // number of ones in a byte
  function automatic logic [3:0] ones8(input logic [BYTE_W-1:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + {3'b000, b[i]};
    return n;
  endfunction

  // stage one: transition-reducing chain, bit 8 = 1 when XOR was used
  function automatic logic [BYTE_W:0] min_trans(input logic [BYTE_W-1:0] d);
    logic [BYTE_W:0] q;
    logic [3:0]      n;
    logic            use_xnor;
    n        = ones8(d);
    use_xnor = (n > 4'd4) || ((n == 4'd4) && !d[0]);
    q[0]     = d[0];
    for (int i = 1; i < BYTE_W; i++)
      q[i] = use_xnor ? ~(q[i-1] ^ d[i]) : (q[i-1] ^ d[i]);
    q[BYTE_W] = ~use_xnor;
    return q;
  endfunction

  // signed imbalance (ones - zeros) of a full character
  function automatic logic signed [DISP_W-1:0] word_imb(input logic [SYM_W-1:0] w);
    logic [3:0] p;
    p = '0;
    for (int i = 0; i < SYM_W; i++) p = p + {3'b000, w[i]};
    return $signed({1'b0, p, 1'b0}) - 6'sd10;
  endfunction

  // fixed blanking tokens
  function automatic logic [SYM_W-1:0] ctrl_token(input logic [1:0] c);
    logic [SYM_W-1:0] t;
    case (c)
      2'b00:   t = 10'b1101010100;
      2'b01:   t = 10'b0010101011;
      2'b10:   t = 10'b0101010100;
      default: t = 10'b1010101011;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/tmds_phase_gen.sv
module tmds_phase_gen #(
  parameter int RATIO = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = $clog2(RATIO);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)               phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/tmds_min_stage.sv
module tmds_min_stage
  import tmds_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W:0]   qm_o
);
  assign qm_o = min_trans(byte_i);
endmodule

// File: rtl/tmds_dc_stage.sv
module tmds_dc_stage
  import tmds_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     de,
  input  logic [1:0]               ctl,
  input  logic [BYTE_W:0]          qm,
  output logic [SYM_W-1:0]         word_o,
  output logic [SYM_W-1:0]         char_q,
  output logic signed [DISP_W-1:0] disp_q
);
  logic [3:0]               n1;
  logic                     inv;
  logic [SYM_W-1:0]         data_word;
  logic signed [DISP_W-1:0] disp_nx;

  always_comb begin
    n1 = ones8(qm[BYTE_W-1:0]);
    if ((disp_q == '0) || (n1 == 4'd4))
      inv = ~qm[BYTE_W];
    else if (((disp_q > 6'sd0) && (n1 > 4'd4)) || ((disp_q < 6'sd0) && (n1 < 4'd4)))
      inv = 1'b1;
    else
      inv = 1'b0;
    data_word = {inv, qm[BYTE_W], inv ? ~qm[BYTE_W-1:0] : qm[BYTE_W-1:0]};
    word_o    = de ? data_word : ctrl_token(ctl);
    disp_nx   = de ? (disp_q + word_imb(data_word)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      char_q <= ctrl_token(2'b00);
      disp_q <= '0;
    end else if (load) begin
      char_q <= word_o;
      disp_q <= disp_nx;
    end
  end
endmodule

// File: rtl/tmds_shifter.sv
module tmds_shifter
  import tmds_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYM_W-1:0] word_i,
  output logic             bit_o
);
  logic [SYM_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= ctrl_token(2'b00);
    else if (load) sh <= word_i;
    else           sh <= {1'b0, sh[SYM_W-1:1]};
  end

  assign bit_o = sh[0];
endmodule

// File: rtl/tmds_lane.sv
module tmds_lane
  import tmds_pkg::*;
#(
  parameter int RATIO = SYM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] pix_in,
  input  logic [1:0]        ctl_in,
  input  logic              de_in,
  output logic              pix_stb,
  output logic [SYM_W-1:0]  char_out,
  output logic              ser_out
);
  logic                     load_w;
  logic [BYTE_W:0]          qm_w;
  logic [SYM_W-1:0]         word_w;
  logic signed [DISP_W-1:0] disp_w;

  tmds_phase_gen #(.RATIO(RATIO)) u_phase (
    .clk (clk),
    .rst (rst),
    .tick(load_w)
  );

  tmds_min_stage u_min (
    .byte_i(pix_in),
    .qm_o  (qm_w)
  );

  tmds_dc_stage u_dc (
    .clk   (clk),
    .rst   (rst),
    .load  (load_w),
    .de    (de_in),
    .ctl   (ctl_in),
    .qm    (qm_w),
    .word_o(word_w),
    .char_q(char_out),
    .disp_q(disp_w)
  );

  tmds_shifter u_sh (
    .clk   (clk),
    .rst   (rst),
    .load  (load_w),
    .word_i(word_w),
    .bit_o (ser_out)
  );

  assign pix_stb = load_w;
endmodule

// File: rtl/tmds_lane_chk.sv
module tmds_lane_chk #(
  parameter int RATIO = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              stb,
  input logic              de,
  input logic signed [5:0] disp,
  input logic              ser,
  input logic [9:0]        chr
);
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (rst || stb) gap <= '0;
    else            gap <= gap + 1'b1;
  end

  a_r2_stb_single: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);

  a_r2_stb_gap: assert property (@(posedge clk) disable iff (rst)
    stb |-> (gap == 8'(RATIO - 1)));

  a_r4_disp_clear: assert property (@(posedge clk) disable iff (rst)
    (stb && !de) |=> (disp == 6'sd0));

  a_r7_disp_bound: assert property (@(posedge clk) disable iff (rst)
    (disp <= 6'sd10) && (disp >= -6'sd10));

  a_r8_first_bit: assert property (@(posedge clk) disable iff (rst)
    $past(stb) |-> (ser == chr[0]));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(stb) |-> $stable(chr));
endmodule

bind tmds_lane tmds_lane_chk #(.RATIO(RATIO)) u_chk (
  .clk (clk),
  .rst (rst),
  .stb (pix_stb),
  .de  (de_in),
  .disp(disp_w),
  .ser (ser_out),
  .chr (char_out)
);

// File: tb/sim_tmds_lane.sv
module sim_tmds_lane;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pix_in = '0;
  logic [1:0] ctl_in = '0;
  logic       de_in  = 1'b0;
  logic       pix_stb;
  logic [9:0] char_out;
  logic       ser_out;

  int checks = 0;
  int errors = 0;
  int mdisp  = 0;
  int rxdisp = 0;
  bit after_ctl = 1'b1;

  tmds_lane u0 (
    .clk(clk), .rst(rst), .pix_in(pix_in), .ctl_in(ctl_in), .de_in(de_in),
    .pix_stb(pix_stb), .char_out(char_out), .ser_out(ser_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pop(input logic [9:0] w);
    int n = 0;
    for (int i = 0; i < 10; i++) if (w[i]) n++;
    return n;
  endfunction

  function automatic logic [9:0] token(input logic [1:0] c);
    logic [9:0] t[4] = '{10'h354, 10'h0AB, 10'h154, 10'h2AB};
    return t[c];
  endfunction

  // independent model of both coding stages; updates the model disparity
  function automatic logic [9:0] model(input logic [7:0] d, input logic [1:0] c, input bit de);
    logic [8:0] q;
    logic [9:0] w;
    int  n;
    bit  xn, inv;
    if (!de) begin
      mdisp = 0;
      return token(c);
    end
    n  = pop({2'b00, d});
    xn = (n > 4) || (n == 4 && d[0] == 1'b0);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = (q[i-1] ^ d[i]) ^ xn;
    q[8] = !xn;
    n = pop({2'b00, q[7:0]});
    if (mdisp == 0 || n == 4) inv = !q[8];
    else                      inv = ((mdisp > 0) == (n > 4));
    w = {inv, q[8], q[7:0] ^ {8{inv}}};
    mdisp += 2 * pop(w) - 10;
    return w;
  endfunction

  function automatic logic [7:0] decode(input logic [9:0] w);
    logic [7:0] v, o;
    v = w[9] ? ~w[7:0] : w[7:0];
    o[0] = v[0];
    for (int i = 1; i < 8; i++) o[i] = w[8] ? (v[i] ^ v[i-1]) : ~(v[i] ^ v[i-1]);
    return o;
  endfunction

  task automatic send(input logic [7:0] d, input logic [1:0] c, input bit de);
    logic [9:0] exp, got, sb;
    while (!pix_stb) @(negedge clk);
    pix_in = d; ctl_in = c; de_in = de;
    exp = model(d, c, de);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sb[i] = ser_out;
      if (i == 0) got = char_out;
      else if (char_out != got) chk(1'b0, "R9", int'(char_out), int'(got));
    end
    if (de) begin
      chk(got == exp, "R6", int'(got), int'(exp));
      chk(decode(sb) == d, "R5", int'(decode(sb)), int'(d));
      if (after_ctl) chk(got[9] == ~got[8], "R4", int'(got[9]), int'(~got[8]));
      rxdisp += 2 * pop(sb) - 10;
      chk(rxdisp <= 10 && rxdisp >= -10, "R7", rxdisp, 10);
    end else begin
      chk(got == token(c), "R3", int'(got), int'(token(c)));
      rxdisp = 0;
    end
    chk(sb == got, "R8", int'(sb), int'(got));
    chk(pix_stb == 1'b1, "R2", int'(pix_stb), 1);
    after_ctl = !de;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] sb;
    repeat (3) @(negedge clk);
    chk(char_out == 10'h354, "R1", int'(char_out), 'h354);
    rst = 1'b0;
    // R1: reset token streams out, R2: first strobe after nine clocks
    for (int i = 0; i < 10; i++) begin
      sb[i] = ser_out;
      if (i < 9) begin
        chk(pix_stb == 1'b0, "R2", int'(pix_stb), 0);
        @(negedge clk);
      end
    end
    chk(sb == 10'h354, "R1", int'(sb), 'h354);
    chk(pix_stb == 1'b1, "R2", int'(pix_stb), 1);
    chk(char_out == 10'h354, "R1", int'(char_out), 'h354);

    for (int c = 0; c < 4; c++) send(8'h00, 2'(c), 1'b0);
    // unbroken data run across every byte value
    for (int b = 0; b < 256; b++) send(8'(b), 2'b00, 1'b1);
    // every byte straight after a control token
    for (int b = 0; b < 256; b++) begin
      send(8'h00, 2'(b), 1'b0);
      send(8'(255 - b), 2'b00, 1'b1);
    end
    // long random runs with sparse blanking
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 99) < 3) send(8'h00, 2'($urandom_range(0, 3)), 1'b0);
      else                           send(8'($urandom_range(0, 255)), 2'b00, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule